// File: doc/BRIEF.md
# MSI Adapter Indicator Router

This block receives message-signalled interrupt writes from devices and turns each into bit updates in host memory. The data word of a write carries a function identifier in its upper bits and a vector number in its low bits. The block looks the function up in a small table of slots. Each slot describes one attached function: its handle, its identifier, where its per-vector indicator bits live, where its summary bit lives, and its interruption subclass.

For a known function, the block first sets the vector's indicator bit and then the function's summary bit. Each update is a read-modify-write of one byte on a byte-wide memory port. An interrupt request goes out only when the summary byte read back was entirely clear. This means that a burst of vectors from one function, arriving before software drains the summary, produces a single interrupt. An unknown function, or a byte address the memory side cannot map, produces an error event instead.

The block handles one write at a time and holds off the next one until both byte updates have finished. Reads of the port have no side effects and return a fixed all-ones word.

Top module: `msi_ind_router`

## Requirements
- R1: The data word splits into a vector number in bits 10:0 and a function identifier in bits 31:11.
- R2: A slot matches only when its handle is nonzero and its identifier equals the decoded identifier. When several slots match, the lowest-numbered slot is used.
- R3: When no slot matches, one error event is emitted with code 1. It carries the decoded identifier, the write address, and a qualifier equal to the vector number shifted left by 16. No memory access is made, and ready stays high.
- R4: The indicator bit position is the slot's indicator offset plus the vector number. Its byte is at the indicator base plus the position divided by 8. Within that byte the bit is selected MSB-first, with mask 0x80 shifted right by the position modulo 8.
- R5: The summary bit is located the same way, from the slot's summary base and summary offset, with a vector number of zero.
- R6: Each bit update reads the byte and then writes back the old value ORed with the mask. All other bits of the byte are preserved. The address and the operation are held steady until each access is acknowledged.
- R7: An interrupt request pulse is issued only when the summary byte read before the update was zero. The accompanying word is the slot's 3-bit subclass shifted left by 27, with bit 31 set as the adapter-interrupt flag.
- R8: The read data output is always 0xFFFFFFFF.
- R9: A read acknowledged with a mapping error produces an error event with code 2, in which the identifier, address and qualifier are all zero, and that byte is not written. After an indicator failure the summary update still takes place. A summary failure suppresses the interrupt.
- R10: Ready falls in the cycle after a write to a known function is accepted, and stays low until both updates have completed. No memory request is made while ready is high.
- R11: After reset, ready is high and no memory request, event or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | Write strobe |
| msi_ready | output | 1 | Block idle and able to take a write |
| msi_data | input | 32 | Write data word (identifier and vector) |
| msi_addr | input | 16 | Write address, reported in the no-function event |
| rd_data | output | 32 | Read data of the port |
| slot_fh | input | NSLOT*32 | Per-slot function handles, zero means empty |
| slot_fid | input | NSLOT*21 | Per-slot function identifiers |
| slot_ind_base | input | NSLOT*16 | Per-slot indicator array byte address |
| slot_ind_off | input | NSLOT*16 | Per-slot indicator bit offset |
| slot_sum_base | input | NSLOT*16 | Per-slot summary byte address |
| slot_sum_off | input | NSLOT*16 | Per-slot summary bit offset |
| slot_isc | input | NSLOT*3 | Per-slot interruption subclass |
| mem_req | output | 1 | Byte memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 8 | Read byte, valid with ack |
| mem_err | input | 1 | Address could not be mapped, valid with ack |
| evt_valid | output | 1 | Error event pulse |
| evt_code | output | 2 | 1 no function, 2 adapter indicator error |
| evt_fid | output | 21 | Event function identifier |
| evt_addr | output | 16 | Event address |
| evt_qual | output | 32 | Event qualifier word |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_word | output | 32 | Interrupt word |

## Verification
A wrong lookup result shows at the ports as either a spurious code-1 event or a byte written into another slot's area. Both are visible within a few cycles of the write being accepted. A wrong bit address or mask leaves the wrong bit set in the memory model once ready returns. This includes a little-endian bit order or a dropped carry from the offset into the byte address. A wrong coalescing decision appears as an extra or missing interrupt pulse on the same transaction. The bench therefore checks memory contents, event fields and interrupt counts after each write. It covers a summary that is already set, an offset that crosses byte boundaries, duplicate identifiers, and errors on each of the two updates.

// File: rtl/msi_rtr_pkg.sv
// Shared encodings for the MSI indicator router.
package msi_rtr_pkg;
    // Error event codes reported on evt_code
    typedef enum logic [1:0] {
        EVT_NONE        = 2'd0,
        EVT_NO_FUNC     = 2'd1,
        EVT_ADAPTER_ERR = 2'd2
    } evt_code_e;

    // Transaction phases of the router
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_IND_GO,
        PH_IND_WAIT,
        PH_SUM_GO,
        PH_SUM_WAIT
    } phase_e;

    // States of the byte read-modify-write engine
    typedef enum logic [1:0] {
        RMW_IDLE,
        RMW_READ,
        RMW_WRITE
    } rmw_state_e;
endpackage

// File: rtl/msi_fn_lookup.sv
// Slot table search.
// Returns the lowest-numbered slot whose handle is nonzero and whose identifier
// equals the requested one. Purely combinational.
// Assumes the table inputs are stable while a lookup is in use.
module msi_fn_lookup #(
    parameter int NSLOT = 4,
    parameter int FH_W  = 32,
    parameter int FID_W = 21,
    parameter int IDX_W = 2
) (
    input  logic [NSLOT*FH_W-1:0]  slot_fh,
    input  logic [NSLOT*FID_W-1:0] slot_fid,
    input  logic [FID_W-1:0]       fid,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [NSLOT-1:0] match;

    // One comparator per slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match[g] = (slot_fh[g*FH_W +: FH_W] != '0) &&
                          (slot_fid[g*FID_W +: FID_W] == fid);
    end

    // Priority pick: the lowest index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msi_bit_locator.sv
// Converts a base byte address, a bit offset and a vector number into a byte
// address and an MSB-first bit mask.
// Assumes the byte address wraps at MADDR_W bits.
module msi_bit_locator #(
    parameter int MADDR_W = 16,
    parameter int OFF_W   = 16,
    parameter int VEC_W   = 11
) (
    input  logic [MADDR_W-1:0] base,
    input  logic [OFF_W-1:0]   offset,
    input  logic [VEC_W-1:0]   vec,
    output logic [MADDR_W-1:0] byte_addr,
    output logic [7:0]         mask
);
    localparam int POS_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] byte_idx;

    // Bit position, byte index and mask
    always_comb begin
        pos       = POS_W'(offset) + POS_W'(vec);
        byte_idx  = pos >> 3;
        byte_addr = base + MADDR_W'(byte_idx);
        mask      = 8'h80 >> pos[2:0];
    end
endmodule

// File: rtl/msi_rmw_engine.sv
// Single-byte atomic OR engine.
// On start it reads the byte, then writes back the old value ORed with the mask.
// done pulses in the cycle of the final acknowledge, with the old byte value.
// A read that fails to map returns 0xFF as the old value, raises failed, and
// skips the write.
// Assumes addr and mask are held stable by the caller until done.
module msi_rmw_engine #(
    parameter int MADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MADDR_W-1:0] addr,
    input  logic [7:0]         mask,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic               mem_ack,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_err,
    output logic               done,
    output logic               failed,
    output logic [7:0]         old_byte
);
    import msi_rtr_pkg::*;

    rmw_state_e st;
    logic [7:0] saved;

    // Sequence read, then write, advancing on each acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RMW_IDLE;
            saved <= 8'h00;
        end else begin
            case (st)
                RMW_IDLE:  if (start) st <= RMW_READ;
                RMW_READ:  if (mem_ack) begin
                               if (mem_err) st <= RMW_IDLE;
                               else begin
                                   saved <= mem_rdata;
                                   st    <= RMW_WRITE;
                               end
                           end
                RMW_WRITE: if (mem_ack) st <= RMW_IDLE;
                default:   st <= RMW_IDLE;
            endcase
        end
    end

    // Memory port drive
    always_comb begin
        mem_req   = (st != RMW_IDLE);
        mem_we    = (st == RMW_WRITE);
        mem_addr  = addr;
        mem_wdata = saved | mask;
    end

    // Completion and result
    always_comb begin
        failed   = (st == RMW_READ) && mem_ack && mem_err;
        done     = failed || ((st == RMW_WRITE) && mem_ack);
        old_byte = failed ? 8'hFF : saved;
    end

    // R6
    rmw_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    rmw_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_ack && !mem_err));

    // R10
    rmw_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !mem_req);
endmodule

// File: rtl/msi_ind_router.sv
// MSI adapter indicator router (top).
// Decodes a write data word into a function identifier and a vector number,
// and finds the function's slot. For a known function it sets the indicator
// bit and then the summary bit through the RMW engine, and raises an interrupt
// if the old summary byte was zero. Unknown functions and unmappable bytes
// produce error events.
// Assumes the slot table is stable while a write is being processed.
module msi_ind_router #(
    parameter int DATA_W     = 32,
    parameter int VEC_W      = 11,
    parameter int NSLOT      = 4,
    parameter int FH_W       = 32,
    parameter int MADDR_W    = 16,
    parameter int OFF_W      = 16,
    parameter int ADDR_W     = 16,
    parameter int ISC_W      = 3,
    parameter int QUAL_SHIFT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         msi_valid,
    output logic                         msi_ready,
    input  logic [DATA_W-1:0]            msi_data,
    input  logic [ADDR_W-1:0]            msi_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [NSLOT*FH_W-1:0]        slot_fh,
    input  logic [NSLOT*(DATA_W-VEC_W)-1:0] slot_fid,
    input  logic [NSLOT*MADDR_W-1:0]     slot_ind_base,
    input  logic [NSLOT*OFF_W-1:0]       slot_ind_off,
    input  logic [NSLOT*MADDR_W-1:0]     slot_sum_base,
    input  logic [NSLOT*OFF_W-1:0]       slot_sum_off,
    input  logic [NSLOT*ISC_W-1:0]       slot_isc,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [MADDR_W-1:0]           mem_addr,
    output logic [7:0]                   mem_wdata,
    input  logic                         mem_ack,
    input  logic [7:0]                   mem_rdata,
    input  logic                         mem_err,
    output logic                         evt_valid,
    output logic [1:0]                   evt_code,
    output logic [DATA_W-VEC_W-1:0]      evt_fid,
    output logic [ADDR_W-1:0]            evt_addr,
    output logic [31:0]                  evt_qual,
    output logic                         irq_valid,
    output logic [31:0]                  irq_word
);
    import msi_rtr_pkg::*;

    localparam int FID_W     = DATA_W - VEC_W;
    localparam int IDX_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int ISC_SHIFT = 27;
    localparam logic [31:0] AI_FLAG = 32'h8000_0000;

    phase_e             phase;
    logic [FID_W-1:0]   dec_fid;
    logic [VEC_W-1:0]   dec_vec;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_idx;

    logic [VEC_W-1:0]   r_vec;
    logic [MADDR_W-1:0] r_ind_base, r_sum_base;
    logic [OFF_W-1:0]   r_ind_off, r_sum_off;
    logic [ISC_W-1:0]   r_isc;

    logic [MADDR_W-1:0] ind_addr, sum_addr;
    logic [7:0]         ind_mask, sum_mask;

    logic               eng_start, eng_done, eng_failed, use_ind;
    logic [MADDR_W-1:0] eng_addr;
    logic [7:0]         eng_mask, eng_old;

    // Field split of the data word
    always_comb begin
        dec_vec = msi_data[VEC_W-1:0];
        dec_fid = msi_data[DATA_W-1:VEC_W];
    end

    assign rd_data   = '1;
    assign msi_ready = (phase == PH_IDLE);

    msi_fn_lookup #(.NSLOT(NSLOT), .FH_W(FH_W), .FID_W(FID_W), .IDX_W(IDX_W)) u_lookup (
        .slot_fh (slot_fh),
        .slot_fid(slot_fid),
        .fid     (dec_fid),
        .hit     (lk_hit),
        .idx     (lk_idx)
    );

    msi_bit_locator #(.MADDR_W(MADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_ind_loc (
        .base     (r_ind_base),
        .offset   (r_ind_off),
        .vec      (r_vec),
        .byte_addr(ind_addr),
        .mask     (ind_mask)
    );

    msi_bit_locator #(.MADDR_W(MADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_sum_loc (
        .base     (r_sum_base),
        .offset   (r_sum_off),
        .vec      ({VEC_W{1'b0}}),
        .byte_addr(sum_addr),
        .mask     (sum_mask)
    );

    // Engine target select: indicator byte first, then summary byte
    always_comb begin
        use_ind   = (phase == PH_IND_GO) || (phase == PH_IND_WAIT);
        eng_start = (phase == PH_IND_GO) || (phase == PH_SUM_GO);
        eng_addr  = use_ind ? ind_addr : sum_addr;
        eng_mask  = use_ind ? ind_mask : sum_mask;
    end

    msi_rmw_engine #(.MADDR_W(MADDR_W)) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .addr     (eng_addr),
        .mask     (eng_mask),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_err  (mem_err),
        .done     (eng_done),
        .failed   (eng_failed),
        .old_byte (eng_old)
    );

    // Transaction sequencing, slot capture, event and interrupt generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            r_vec      <= '0;
            r_ind_base <= '0;
            r_ind_off  <= '0;
            r_sum_base <= '0;
            r_sum_off  <= '0;
            r_isc      <= '0;
            evt_valid  <= 1'b0;
            evt_code   <= EVT_NONE;
            evt_fid    <= '0;
            evt_addr   <= '0;
            evt_qual   <= '0;
            irq_valid  <= 1'b0;
            irq_word   <= '0;
        end else begin
            evt_valid <= 1'b0;
            irq_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (msi_valid) begin
                    if (lk_hit) begin
                        r_vec      <= dec_vec;
                        r_ind_base <= slot_ind_base[lk_idx*MADDR_W +: MADDR_W];
                        r_ind_off  <= slot_ind_off[lk_idx*OFF_W +: OFF_W];
                        r_sum_base <= slot_sum_base[lk_idx*MADDR_W +: MADDR_W];
                        r_sum_off  <= slot_sum_off[lk_idx*OFF_W +: OFF_W];
                        r_isc      <= slot_isc[lk_idx*ISC_W +: ISC_W];
                        phase      <= PH_IND_GO;
                    end else begin
                        evt_valid <= 1'b1;
                        evt_code  <= EVT_NO_FUNC;
                        evt_fid   <= dec_fid;
                        evt_addr  <= msi_addr;
                        evt_qual  <= 32'(dec_vec) << QUAL_SHIFT;
                    end
                end
                PH_IND_GO:   phase <= PH_IND_WAIT;
                PH_IND_WAIT: if (eng_done) begin
                    if (eng_failed) begin
                        evt_valid <= 1'b1;
                        evt_code  <= EVT_ADAPTER_ERR;
                        evt_fid   <= '0;
                        evt_addr  <= '0;
                        evt_qual  <= '0;
                    end
                    phase <= PH_SUM_GO;
                end
                PH_SUM_GO:   phase <= PH_SUM_WAIT;
                PH_SUM_WAIT: if (eng_done) begin
                    if (eng_failed) begin
                        evt_valid <= 1'b1;
                        evt_code  <= EVT_ADAPTER_ERR;
                        evt_fid   <= '0;
                        evt_addr  <= '0;
                        evt_qual  <= '0;
                    end else if (eng_old == 8'h00) begin
                        irq_valid <= 1'b1;
                        irq_word  <= (32'(r_isc) << ISC_SHIFT) | AI_FLAG;
                    end
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready);

    // R3
    miss_event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EVT_NO_FUNC) |-> $past(msi_valid && msi_ready));

    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (!evt_valid && irq_word[31]));

    // R9
    adapter_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EVT_ADAPTER_ERR) |-> (evt_fid == '0 && evt_qual == '0));

    // R2
    lookup_handle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_ready && lk_hit) |-> (slot_fh[lk_idx*FH_W +: FH_W] != '0));
endmodule

// File: tb/msi_ind_router_tb.sv
`timescale 1ns/1ps
module msi_ind_router_tb;
    localparam int NSLOT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic msi_valid = 1'b0;
    logic msi_ready;
    logic [31:0] msi_data = '0;
    logic [15:0] msi_addr = '0;
    logic [31:0] rd_data;
    logic [NSLOT*32-1:0] slot_fh = '0;
    logic [NSLOT*21-1:0] slot_fid = '0;
    logic [NSLOT*16-1:0] slot_ind_base = '0, slot_ind_off = '0;
    logic [NSLOT*16-1:0] slot_sum_base = '0, slot_sum_off = '0;
    logic [NSLOT*3-1:0]  slot_isc = '0;
    logic mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic mem_err = 1'b0;
    logic evt_valid;
    logic [1:0] evt_code;
    logic [20:0] evt_fid;
    logic [15:0] evt_addr;
    logic [31:0] evt_qual;
    logic irq_valid;
    logic [31:0] irq_word;

    msi_ind_router u_dut (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_data(msi_data), .msi_addr(msi_addr), .rd_data(rd_data),
        .slot_fh(slot_fh), .slot_fid(slot_fid), .slot_ind_base(slot_ind_base),
        .slot_ind_off(slot_ind_off), .slot_sum_base(slot_sum_base),
        .slot_sum_off(slot_sum_off), .slot_isc(slot_isc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_fid(evt_fid),
        .evt_addr(evt_addr), .evt_qual(evt_qual),
        .irq_valid(irq_valid), .irq_word(irq_word)
    );

    // Memory model: 256 mapped bytes, one-cycle acknowledge, error above
    logic [7:0] mem [256];
    int n_checks = 0, n_fail = 0;
    int evt_cnt = 0, irq_cnt = 0, wr_cnt = 0;
    logic [1:0] last_code;
    logic [20:0] last_fid;
    logic [15:0] last_addr;
    logic [31:0] last_qual, last_irq;
    logic last_busy;

    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            mem_err   <= (mem_addr >= 16'd256);
            mem_rdata <= (mem_addr < 16'd256) ? mem[mem_addr[7:0]] : 8'h00;
        end
        if (mem_req && mem_ack && mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr < 16'd256) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (evt_valid) begin
            evt_cnt  <= evt_cnt + 1;
            last_code <= evt_code; last_fid <= evt_fid;
            last_addr <= evt_addr; last_qual <= evt_qual;
        end
        if (irq_valid) begin
            irq_cnt  <= irq_cnt + 1;
            last_irq <= irq_word;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_slot(input int s, input logic [31:0] fh, input logic [20:0] fid,
                            input logic [15:0] ib, input logic [15:0] io,
                            input logic [15:0] sb, input logic [15:0] so, input logic [2:0] isc);
        slot_fh[s*32 +: 32] = fh;
        slot_fid[s*21 +: 21] = fid;
        slot_ind_base[s*16 +: 16] = ib;
        slot_ind_off[s*16 +: 16] = io;
        slot_sum_base[s*16 +: 16] = sb;
        slot_sum_off[s*16 +: 16] = so;
        slot_isc[s*3 +: 3] = isc;
    endtask

    // Issue one write and wait until the block is idle again
    task automatic send(input logic [20:0] fid, input logic [10:0] vec, input logic [15:0] a);
        @(negedge clk);
        msi_data = {fid, vec};
        msi_addr = a;
        msi_valid = 1'b1;
        while (!msi_ready) @(negedge clk);
        @(negedge clk);
        msi_valid = 1'b0;
        last_busy = !msi_ready;
        while (!msi_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 ready", msi_ready, 1);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 evt", evt_valid, 0);
        chk("R11 irq", irq_valid, 0);
        chk("R8 rd_data", rd_data, 32'hFFFF_FFFF);
    endtask

    task automatic t_basic;
        int e0 = evt_cnt, i0 = irq_cnt, w0 = wr_cnt;
        set_slot(0, 32'h105, 21'd5, 16'h10, 16'd0, 16'h40, 16'd2, 3'd5);
        send(21'd5, 11'd3, 16'h0);
        chk("R10 busy after accept", last_busy, 1);
        chk("R4 indicator byte", mem[8'h10], 8'h10);
        chk("R5 summary byte", mem[8'h40], 8'h20);
        chk("R7 irq count", irq_cnt - i0, 1);
        chk("R7 irq word", last_irq, 32'hA800_0000);
        chk("R1 no event", evt_cnt - e0, 0);
        chk("R6 two writes", wr_cnt - w0, 2);
        chk("R8 rd_data", rd_data, 32'hFFFF_FFFF);
    endtask

    task automatic t_coalesce;
        int i0 = irq_cnt;
        mem[8'h11] = 8'h41;
        send(21'd5, 11'd12, 16'h0);
        chk("R6 preserve bits", mem[8'h11], 8'h49);
        chk("R6 summary unchanged", mem[8'h40], 8'h20);
        chk("R7 coalesced no irq", irq_cnt - i0, 0);
    endtask

    task automatic t_cross_dup;
        int i0 = irq_cnt;
        set_slot(1, 32'h109, 21'd9, 16'h20, 16'd13, 16'h48, 16'd9, 3'd2);
        set_slot(3, 32'h10B, 21'd9, 16'h30, 16'd0, 16'h58, 16'd0, 3'd7);
        send(21'd9, 11'd7, 16'h0);
        chk("R4 crossing offset", mem[8'h22], 8'h08);
        chk("R5 summary offset", mem[8'h49], 8'h40);
        chk("R2 lowest slot ind", mem[8'h30], 8'h00);
        chk("R2 lowest slot sum", mem[8'h58], 8'h00);
        chk("R7 irq word isc2", last_irq, 32'h9000_0000);
        chk("R7 irq count", irq_cnt - i0, 1);
    endtask

    task automatic t_zero_handle;
        int e0 = evt_cnt, w0 = wr_cnt;
        set_slot(2, 32'h0, 21'd33, 16'h80, 16'd0, 16'h90, 16'd0, 3'd1);
        send(21'd33, 11'h2A, 16'h1234);
        chk("R2 empty slot misses", evt_cnt - e0, 1);
        chk("R3 code", last_code, 2'd1);
        chk("R3 fid", last_fid, 21'd33);
        chk("R3 addr", last_addr, 16'h1234);
        chk("R3 qualifier", last_qual, 32'h002A_0000);
        chk("R3 no memory", wr_cnt - w0, 0);
        chk("R10 ready stays high", last_busy, 0);
    endtask

    task automatic t_unknown;
        send(21'h1FFFF5, 11'h7FF, 16'hBEEF);
        chk("R1 fid upper bits", last_fid, 21'h1FFFF5);
        chk("R1 vec low bits", last_qual, 32'h07FF_0000);
    endtask

    task automatic t_ind_err;
        int e0 = evt_cnt, i0 = irq_cnt, w0 = wr_cnt;
        set_slot(0, 32'h105, 21'd5, 16'h1F0, 16'd0, 16'h60, 16'd0, 3'd1);
        send(21'd5, 11'd0, 16'h0);
        chk("R9 ind err event", evt_cnt - e0, 1);
        chk("R9 code", last_code, 2'd2);
        chk("R9 zero fid", last_fid, 0);
        chk("R9 zero addr", last_addr, 0);
        chk("R9 summary still set", mem[8'h60], 8'h80);
        chk("R9 irq after ind err", irq_cnt - i0, 1);
        chk("R9 irq word", last_irq, 32'h8800_0000);
        chk("R9 one write", wr_cnt - w0, 1);
    endtask

    task automatic t_sum_err;
        int e0 = evt_cnt, i0 = irq_cnt;
        set_slot(0, 32'h105, 21'd5, 16'h70, 16'd0, 16'h300, 16'd0, 3'd1);
        send(21'd5, 11'd1, 16'h0);
        chk("R9 indicator set", mem[8'h70], 8'h40);
        chk("R9 sum err event", evt_cnt - e0, 1);
        chk("R9 sum err code", last_code, 2'd2);
        chk("R9 no irq", irq_cnt - i0, 0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_coalesce();
        t_cross_dup();
        t_zero_handle();
        t_unknown();
        t_ind_err();
        t_sum_err();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule